// File: doc/BRIEF.md
# Programmable Carrier Modulator

This block produces a divided-down carrier for a high-current LED output, for example the drive of an infrared transmitter. Software programs an on-time count and a three-bit ratio mode; the block turns these into a repeating pattern of high cycles followed by low cycles, counted in system clock cycles. A gate level, taken from the output pin's data bit, switches the carrier on and off. A timer overflow may also set or clear that bit, and so gate the carrier.

A control write is held as a pending setting. It becomes active only when the current carrier period wraps, or at any time while the gate is low, so the output never shows a shortened or stretched pulse. Every period starts with its high phase. Dropping the gate forces the output low and restarts the phase count.

Top module: `carrier_mod`

## Requirements
- R1: The high phase lasts on-count + 1 cycles, and one carrier period lasts the high phase plus the low phase.
- R2: The mode selects the low phase length relative to the high-phase length H. Mode 000 gives H, mode 001 gives 2H, mode 010 gives 3H, mode 011 gives H/2 rounded down, and mode 100 gives H/3 rounded down.
- R3: Mode 111 selects the fastest carrier a registered output can make: one cycle high, one cycle low. The on-count is ignored.
- R4: Modes 101 and 110 are reserved. While one of them is active, the output stays low.
- R5: When the gate is low at a clock edge, the output is low after that edge and the phase count restarts from the beginning of a period.
- R6: A written setting becomes active at the edge that ends the current period, or at any edge where the gate is low. A write in the same cycle as such an edge applies at once. Writes at other times do not change the current period.
- R7: Each period begins with its high phase. The first edge that samples the gate high drives the output high, unless a reserved mode is active.
- R8: A rounded-down low phase of zero is stretched to one cycle.
- R9: Synchronous active-high reset drives the output low and sets both the pending and the active setting to on-count 0, mode 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the pending setting |
| cfg_on | input | ON_W | On-count written with cfg_we |
| cfg_mode | input | 3 | Ratio mode written with cfg_we |
| gate | input | 1 | Pin data level that enables the carrier |
| mod_out | output | 1 | Registered modulated carrier |

## Verification
A control write can land in the very cycle in which the period wraps, so the setting being loaded and the setting being written meet at the same edge. Directed steps place a write exactly on the last cycle of a period, and also one cycle before and one cycle after it. Random steps repeat this many times using short periods and frequent writes. A per-cycle bench model of R1, R2 and R6 checks that the new setting governs the very next period, and that a write one cycle early or late does not.

// File: rtl/carmod_pkg.sv
package carmod_pkg;
  typedef enum logic [2:0] {
    RAT_EQ    = 3'b000,
    RAT_DBL   = 3'b001,
    RAT_TRP   = 3'b010,
    RAT_HALF  = 3'b011,
    RAT_THIRD = 3'b100,
    RAT_RSV_A = 3'b101,
    RAT_RSV_B = 3'b110,
    RAT_FAST  = 3'b111
  } ratio_e;
endpackage

// File: rtl/cm_cfg_reg.sv
module cm_cfg_reg #(
  parameter int ON_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [ON_W-1:0] on_in,
  input  logic [2:0]      mode_in,
  input  logic            load,
  output logic [ON_W-1:0] act_on,
  output logic [2:0]      act_mode
);
  logic [ON_W-1:0] pend_on;
  logic [2:0]      pend_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_on   <= '0;
      pend_mode <= '0;
      act_on    <= '0;
      act_mode  <= '0;
    end else begin
      if (we) begin
        pend_on   <= on_in;
        pend_mode <= mode_in;
      end
      if (load) begin
        act_on   <= we ? on_in   : pend_on;
        act_mode <= we ? mode_in : pend_mode;
      end
    end
  end
endmodule

// File: rtl/cm_ratio.sv
module cm_ratio
  import carmod_pkg::*;
#(
  parameter int ON_W = 8,
  parameter int CW   = ON_W + 3
) (
  input  logic [ON_W-1:0] act_on,
  input  logic [2:0]      act_mode,
  output logic [CW-1:0]   ton,
  output logic [CW-1:0]   per
);
  logic [CW-1:0] base;
  logic [CW-1:0] toff;

  always_comb begin
    base = CW'(act_on) + CW'(1);
    ton  = base;
    toff = base;
    case (ratio_e'(act_mode))
      RAT_EQ:    toff = base;
      RAT_DBL:   toff = base << 1;
      RAT_TRP:   toff = base + (base << 1);
      RAT_HALF:  toff = base >> 1;
      RAT_THIRD: toff = base / CW'(3);
      RAT_FAST: begin
        ton  = CW'(1);
        toff = CW'(1);
      end
      default: begin
        ton  = '0;
        toff = CW'(1);
      end
    endcase
    if (toff == '0) toff = CW'(1);
    per = ton + toff;
  end
endmodule

// File: rtl/cm_phase.sv
module cm_phase #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  input  logic [CW-1:0] ton,
  input  logic [CW-1:0] per,
  output logic          mod_out,
  output logic          load,
  output logic [CW-1:0] cnt
);
  logic wrap;

  assign wrap = (cnt == per - CW'(1));
  assign load = !gate || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      mod_out <= 1'b0;
    end else if (!gate) begin
      cnt     <= '0;
      mod_out <= 1'b0;
    end else begin
      mod_out <= (cnt < ton);
      cnt     <= wrap ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/carrier_mod.sv
module carrier_mod #(
  parameter int ON_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [ON_W-1:0] cfg_on,
  input  logic [2:0]      cfg_mode,
  input  logic            gate,
  output logic            mod_out
);
  localparam int CW = ON_W + 3;

  logic [ON_W-1:0] act_on;
  logic [2:0]      act_mode;
  logic [CW-1:0]   ton;
  logic [CW-1:0]   per;
  logic [CW-1:0]   cnt;
  logic            load;

  cm_cfg_reg #(.ON_W(ON_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .on_in(cfg_on), .mode_in(cfg_mode),
    .load(load), .act_on(act_on), .act_mode(act_mode)
  );

  cm_ratio #(.ON_W(ON_W), .CW(CW)) u_ratio (
    .act_on(act_on), .act_mode(act_mode), .ton(ton), .per(per)
  );

  cm_phase #(.CW(CW)) u_phase (
    .clk(clk), .rst(rst), .gate(gate), .ton(ton), .per(per),
    .mod_out(mod_out), .load(load), .cnt(cnt)
  );
endmodule

// File: rtl/carrier_mod_chk.sv
module carrier_mod_chk #(
  parameter int ON_W = 8,
  parameter int CW   = ON_W + 3
) (
  input logic            clk,
  input logic            rst,
  input logic            gate,
  input logic            mod_out,
  input logic            load,
  input logic [ON_W-1:0] act_on,
  input logic [2:0]      act_mode,
  input logic [CW-1:0]   cnt,
  input logic [CW-1:0]   per
);
  assert_reset_low_R9: assert property (@(posedge clk) rst |=> !mod_out);

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (rst)
    !gate |=> (!mod_out && cnt == '0));

  assert_hold_setting_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_on) && $stable(act_mode)));

  assert_phase_in_period_R1: assert property (@(posedge clk) disable iff (rst)
    cnt < per);

  assert_reserved_low_R4: assert property (@(posedge clk) disable iff (rst)
    (act_mode == 3'b101 || act_mode == 3'b110) |=> !mod_out);
endmodule

bind carrier_mod carrier_mod_chk #(.ON_W(ON_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .gate(gate), .mod_out(mod_out), .load(load),
  .act_on(act_on), .act_mode(act_mode), .cnt(cnt), .per(per)
);

// File: tb/carrier_mod_tb.sv
module carrier_mod_tb;
  localparam int ON_W = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [ON_W-1:0] cfg_on = '0;
  logic [2:0]      cfg_mode = '0;
  logic            gate = 1'b0;
  logic            mod_out;

  int n_chk = 0;
  int n_bad = 0;

  int m_pon = 0, m_pmode = 0, m_aon = 0, m_amode = 0, m_pos = 0;
  bit m_out = 0;

  always #10 clk = ~clk;

  carrier_mod #(.ON_W(ON_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_on(cfg_on),
    .cfg_mode(cfg_mode), .gate(gate), .mod_out(mod_out)
  );

  function automatic int ton_of(int on, int mode);
    if (mode == 7) return 1;
    if (mode == 5 || mode == 6) return 0;
    return on + 1;
  endfunction

  function automatic int per_of(int on, int mode);
    int h = on + 1;
    int lo;
    case (mode)
      0: lo = h;
      1: lo = 2 * h;
      2: lo = 3 * h;
      3: lo = h / 2;
      4: lo = h / 3;
      default: lo = 1;
    endcase
    if (lo < 1) lo = 1;
    return ton_of(on, mode) + lo;
  endfunction

  function automatic string auto_tag(bit g, int mode);
    if (!g) return "R5";
    if (mode == 7) return "R3";
    if (mode == 5 || mode == 6) return "R4";
    return "R2";
  endfunction

  task automatic check(bit exp, string tag);
    n_chk++;
    if (mod_out !== exp) begin
      n_bad++;
      $display("FAIL %s: mod_out actual %0b expected %0b at %0t", tag, mod_out, exp, $time);
    end
  endtask

  task automatic step(bit g, bit we, int on, int mode, string tag);
    int np_on, np_mode, t, p;
    string tg;
    gate = g; cfg_we = we; cfg_on = ON_W'(on); cfg_mode = 3'(mode);
    np_on = we ? on : m_pon;
    np_mode = we ? mode : m_pmode;
    tg = (tag == "") ? auto_tag(g, m_amode) : tag;
    if (!g) begin
      m_out = 0; m_pos = 0; m_aon = np_on; m_amode = np_mode;
    end else begin
      t = ton_of(m_aon, m_amode);
      p = per_of(m_aon, m_amode);
      m_out = (m_pos < t);
      if (m_pos == p - 1) begin
        m_pos = 0; m_aon = np_on; m_amode = np_mode;
      end else m_pos++;
    end
    m_pon = np_on; m_pmode = np_mode;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    check(m_out, tg);
  endtask

  task automatic run(bit g, int n, string tag);
    for (int i = 0; i < n; i++) step(g, 1'b0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g, on, mode, pos_before;
    void'($urandom(32'd2718));
    // R9: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, "R9");
    rst = 1'b0;
    run(1'b0, 2, "R9");
    run(1'b1, 6, "R9");            // defaults: 1 high, 1 low
    run(1'b0, 2, "R5");

    // R1/R7: on-count 4, equal ratio -> 5 high, 5 low, starts high
    step(1'b0, 1'b1, 4, 0, "R1");
    step(1'b1, 1'b0, 0, 0, "R7");
    run(1'b1, 14, "R1");
    run(1'b0, 2, "R5");

    // R2: each ratio code
    for (int md = 0; md < 5; md++) begin
      step(1'b0, 1'b1, 5, md, "R2");
      run(1'b1, 3 * per_of(5, md), "R2");
    end
    run(1'b0, 1, "R5");

    // R8: truncation and clamping of the low phase
    step(1'b0, 1'b1, 0, 3, "R8");
    run(1'b1, 6, "R8");
    step(1'b0, 1'b1, 4, 4, "R8");
    run(1'b1, 12, "R8");
    step(1'b0, 1'b1, 0, 4, "R8");
    run(1'b1, 6, "R8");

    // R3: fastest carrier, on-count ignored
    step(1'b0, 1'b1, 9, 7, "R3");
    run(1'b1, 8, "R3");

    // R4: reserved codes stay low
    step(1'b0, 1'b1, 3, 5, "R4");
    run(1'b1, 8, "R4");
    step(1'b0, 1'b1, 3, 6, "R4");
    run(1'b1, 8, "R4");

    // R6: writes mid-period, one early, on the wrap, one late
    step(1'b0, 1'b1, 3, 0, "R6");  // period 8
    run(1'b1, 3, "R6");
    step(1'b1, 1'b1, 0, 2, "R6");  // mid-period write, wait for wrap
    run(1'b1, 12, "R6");
    step(1'b0, 1'b1, 2, 0, "R6");  // period 6
    run(1'b1, 4, "R6");
    step(1'b1, 1'b1, 1, 1, "R6");  // one cycle before last cycle
    run(1'b1, 10, "R6");
    step(1'b0, 1'b1, 2, 0, "R6");
    run(1'b1, 5, "R6");
    step(1'b1, 1'b1, 0, 7, "R6");  // on the wrap cycle itself
    run(1'b1, 6, "R6");
    step(1'b0, 1'b1, 2, 0, "R6");
    run(1'b1, 6, "R6");
    step(1'b1, 1'b1, 1, 0, "R6");  // one cycle after the wrap
    run(1'b1, 12, "R6");

    // R5: gate drops during a high phase
    step(1'b0, 1'b1, 6, 0, "R5");
    run(1'b1, 3, "R5");
    run(1'b0, 1, "R5");
    run(1'b1, 4, "R7");

    // random mix
    g = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) g = ~g & 1;
      on = $urandom_range(0, 6);
      mode = $urandom_range(0, 7);
      pos_before = m_pos;
      step(g[0], ($urandom_range(0, 19) == 0), on, mode,
           (g != 0 && pos_before == 0) ? "R7" : "");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule